// File: doc/BRIEF.md
# PWM Break Protection Controller

This block sits between a compare stage and the pins of one complementary PWM pair. In normal running it takes the reference waveform, applies a selectable output mode, and inserts a programmable deadtime before either output of the pair goes active. A fault input, once enabled and at its selected level, clears the main output enable (MOE) without waiting for a clock edge. That forces both pins to their inactive levels at once.

When a clock is running, the block then resynchronises MOE through two flops and waits out the deadtime. After that it moves the pins to their programmed idle levels. Re-arming works in one of two ways: automatically on the next update-event pulse, or by a software write. Neither is possible while the fault is still present. A sticky break flag records each fault and can raise an interrupt request. A write-once lock freezes the protection settings in three levels.

The safe-state sequencer has three states: `ST_RUN` (deadtime PWM), `ST_FORCE` (both pins inactive while the deadtime runs down) and `ST_IDLE` (idle levels applied). Reset enters `ST_IDLE`. The transitions are:
- RUN→FORCE when the synchronised MOE is low;
- FORCE→IDLE when the deadtime count has reached zero;
- FORCE→RUN and IDLE→RUN when the synchronised MOE is high.

Registers are written through `wr_en`/`wr_sel`/`wr_data`:
- sel 0, arm: bit0 is the MOE value, bit1 is the flag bit, bit2 is the interrupt enable.
- sel 1, guard: bit0 is the break enable, bit1 the break level (1 means active high), bit2 auto re-arm, bit3 the main idle pin level, bit4 the complementary idle pin level.
- sel 2, polarity: bit0 is the main polarity, bit1 the complementary polarity (0 means active high), bit2 off-state select, bit3 and bit4 the main and complementary channel enables.
- sel 3, mode, bits 1:0.
- sel 4, lock, bits 1:0.
- sel 5, deadtime D, in clock cycles.

Top module: `pwm_guard`

## Requirements
- R1: With the break enabled and `brk_i` equal to the break-level bit, `moe_o` goes low and both pins go to their inactive level (pin = polarity bit) with no clock edge needed.
- R2: With the break enable bit at 0, `brk_i` has no effect on `moe_o` or the pins.
- R3: After a break, the pins stay inactive through the (D+3)th rising edge and show the idle levels from the (D+4)th rising edge.
- R4: The main and complementary pins are never active together. If both idle levels are active levels, the complementary pin is held inactive.
- R5: While MOE is high, each pin enable equals its channel enable bit. While MOE is low, off-state select 1 keeps the channel enable bits and 0 drives both enables low.
- R6: A break sets `brk_flag`, which stays set until an arm write with bit1 = 0 while the break is inactive. `irq` is `brk_flag` AND the interrupt enable.
- R7: With auto re-arm set, an `upd_i` pulse sets MOE. With it clear, MOE stays low until an arm write with bit0 = 1.
- R8: While the break is active, neither a software write nor an update event can set MOE.
- R9: The lock field accepts only the first write after reset. Level 1 or more ignores guard writes, level 2 or more ignores polarity writes, and level 3 ignores mode writes.
- R10: In run, the main logical output goes active after the (D+1)th rising edge after the mode-applied reference rises. The complementary output does the same after it falls. Pin = logical XOR polarity.
- R11: Mode 0 passes the reference, 1 forces it low, 2 forces it high, and 3 inverts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ref_i | input | 1 | reference waveform from compare stage |
| upd_i | input | 1 | update-event pulse |
| brk_i | input | 1 | fault input |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 3 | register select |
| wr_data | input | 8 | register write data |
| pwm_p | output | 1 | main output pin |
| pwm_n | output | 1 | complementary output pin |
| pen_p | output | 1 | main output enable |
| pen_n | output | 1 | complementary output enable |
| moe_o | output | 1 | current main output enable |
| brk_flag | output | 1 | sticky break flag |
| irq | output | 1 | break interrupt request |

## Verification
The bench samples the pins one nanosecond after the fault rises, between clock edges. A design that cleared MOE only on a clock edge would show the old PWM levels there. It counts edges to the exact deadtime boundary after a break, so a design that skipped the two-flop resynchronisation would reach idle early. It tries to re-arm and to clear the flag while the fault is held, and it sets both idle levels active, to catch a pair driven active together. It also writes the lock a second time to catch a lock that can be raised after it was set, and it compares randomised references, modes, polarities and deadtimes against a cycle model.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_FORCE, ST_IDLE} gstate_t;

    localparam logic [2:0] SEL_ARM   = 3'd0;
    localparam logic [2:0] SEL_GUARD = 3'd1;
    localparam logic [2:0] SEL_POL   = 3'd2;
    localparam logic [2:0] SEL_MODE  = 3'd3;
    localparam logic [2:0] SEL_LOCK  = 3'd4;
    localparam logic [2:0] SEL_DT    = 3'd5;

    localparam logic [1:0] MODE_REF  = 2'd0;
    localparam logic [1:0] MODE_LOW  = 2'd1;
    localparam logic [1:0] MODE_HIGH = 2'd2;
    localparam logic [1:0] MODE_INV  = 2'd3;
endpackage

// File: rtl/pwm_guard_regs.sv
module pwm_guard_regs
    import pwm_guard_pkg::*;
#(
    parameter int DW  = 8,
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [DW-1:0]  wr_data,
    output logic           brk_en,
    output logic           brk_lvl,
    output logic           auto_oe,
    output logic           idle_p,
    output logic           idle_n,
    output logic           pol_p,
    output logic           pol_n,
    output logic           off_sel,
    output logic           chen_p,
    output logic           chen_n,
    output logic [1:0]     mode,
    output logic [DTW-1:0] dt,
    output logic           bie,
    output logic           arm_we,
    output logic           arm_val,
    output logic           flag_clr
);
    logic [1:0] lock_lvl;
    logic       lock_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {brk_en, brk_lvl, auto_oe, idle_p, idle_n} <= '0;
            {pol_p, pol_n, off_sel, chen_p, chen_n}    <= '0;
            mode      <= MODE_REF;
            dt        <= '0;
            bie       <= 1'b0;
            lock_lvl  <= 2'd0;
            lock_done <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ARM:   bie <= wr_data[2];
                SEL_GUARD: if (lock_lvl < 2'd1)
                    {idle_n, idle_p, auto_oe, brk_lvl, brk_en} <= wr_data[4:0];
                SEL_POL: begin
                    {chen_n, chen_p} <= wr_data[4:3];
                    if (lock_lvl < 2'd2)
                        {off_sel, pol_n, pol_p} <= wr_data[2:0];
                end
                SEL_MODE:  if (lock_lvl < 2'd3) mode <= wr_data[1:0];
                SEL_LOCK:  if (!lock_done) begin
                    lock_lvl  <= wr_data[1:0];
                    lock_done <= 1'b1;
                end
                SEL_DT:    dt <= wr_data[DTW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        arm_we   = wr_en && (wr_sel == SEL_ARM);
        arm_val  = wr_data[0];
        flag_clr = arm_we && !wr_data[1];
    end
endmodule

// File: rtl/pwm_guard_dtgen.sv
module pwm_guard_dtgen
    import pwm_guard_pkg::*;
#(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_i,
    input  logic [1:0]     mode,
    input  logic [DTW-1:0] dt,
    output logic           act_p,
    output logic           act_n
);
    logic           m;
    logic           m_q;
    logic [DTW-1:0] dtc;

    always_comb begin
        unique case (mode)
            MODE_REF:  m = ref_i;
            MODE_LOW:  m = 1'b0;
            MODE_HIGH: m = 1'b1;
            MODE_INV:  m = ~ref_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= 1'b0;
            dtc <= '0;
        end else begin
            m_q <= m;
            if (m != m_q)      dtc <= dt;
            else if (dtc != 0) dtc <= dtc - 1'b1;
        end
    end

    assign act_p = m_q  && (dtc == '0);
    assign act_n = !m_q && (dtc == '0);
endmodule

// File: rtl/pwm_guard_safe.sv
module pwm_guard_safe
    import pwm_guard_pkg::*;
#(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           brk_act,
    input  logic           upd_i,
    input  logic           auto_oe,
    input  logic           arm_we,
    input  logic           arm_val,
    input  logic           flag_clr,
    input  logic [DTW-1:0] dt,
    output logic           moe,
    output logic           flag,
    output gstate_t        state
);
    gstate_t        state_nx;
    logic           moe_q1, moe_s;
    logic [DTW-1:0] fcnt;

    always_ff @(posedge clk or negedge rst_n or posedge brk_act) begin
        if (!rst_n) begin
            moe  <= 1'b0;
            flag <= 1'b0;
        end else if (brk_act) begin
            moe  <= 1'b0;
            flag <= 1'b1;
        end else begin
            if (arm_we)                moe <= arm_val;
            else if (upd_i && auto_oe) moe <= 1'b1;
            if (flag_clr)              flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moe_q1 <= 1'b0;
            moe_s  <= 1'b0;
        end else begin
            moe_q1 <= moe;
            moe_s  <= moe_q1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fcnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN && !moe_s)             fcnt <= dt;
            else if (state == ST_FORCE && fcnt != '0)  fcnt <= fcnt - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (!moe_s) state_nx = ST_FORCE;
            ST_FORCE: if (moe_s) state_nx = ST_RUN;
                      else if (fcnt == '0) state_nx = ST_IDLE;
            ST_IDLE:  if (moe_s) state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
    import pwm_guard_pkg::*;
#(
    parameter int DW  = 8,
    parameter int DTW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_i,
    input  logic          upd_i,
    input  logic          brk_i,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          pwm_p,
    output logic          pwm_n,
    output logic          pen_p,
    output logic          pen_n,
    output logic          moe_o,
    output logic          brk_flag,
    output logic          irq
);
    logic brk_en, brk_lvl, auto_oe, idle_p, idle_n;
    logic pol_p, pol_n, off_sel, chen_p, chen_n, bie;
    logic arm_we, arm_val, flag_clr;
    logic [1:0]     mode;
    logic [DTW-1:0] dt;
    logic act_p, act_n, brk_act, moe, flag, idle_n_eff;
    gstate_t state;

    pwm_guard_regs #(.DW(DW), .DTW(DTW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .brk_en(brk_en), .brk_lvl(brk_lvl), .auto_oe(auto_oe), .idle_p(idle_p),
        .idle_n(idle_n), .pol_p(pol_p), .pol_n(pol_n), .off_sel(off_sel),
        .chen_p(chen_p), .chen_n(chen_n), .mode(mode), .dt(dt), .bie(bie),
        .arm_we(arm_we), .arm_val(arm_val), .flag_clr(flag_clr)
    );

    pwm_guard_dtgen #(.DTW(DTW)) u_dt (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .mode(mode), .dt(dt),
        .act_p(act_p), .act_n(act_n)
    );

    assign brk_act = brk_en && (brk_i == brk_lvl);

    pwm_guard_safe #(.DTW(DTW)) u_safe (
        .clk(clk), .rst_n(rst_n), .brk_act(brk_act), .upd_i(upd_i),
        .auto_oe(auto_oe), .arm_we(arm_we), .arm_val(arm_val),
        .flag_clr(flag_clr), .dt(dt), .moe(moe), .flag(flag), .state(state)
    );

    always_comb begin
        idle_n_eff = ((idle_p != pol_p) && (idle_n != pol_n)) ? pol_n : idle_n;
        if (state == ST_IDLE) begin
            pwm_p = idle_p;
            pwm_n = idle_n_eff;
        end else if (!moe || state == ST_FORCE) begin
            pwm_p = pol_p;
            pwm_n = pol_n;
        end else begin
            pwm_p = act_p ^ pol_p;
            pwm_n = act_n ^ pol_n;
        end
        pen_p    = chen_p && (moe || off_sel);
        pen_n    = chen_n && (moe || off_sel);
        moe_o    = moe;
        brk_flag = flag;
        irq      = flag && bie;
    end
endmodule

// File: rtl/pwm_guard_chk.sv
module pwm_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic brk_act,
    input logic moe,
    input logic flag,
    input logic pwm_p,
    input logic pwm_n,
    input logic pol_p,
    input logic pol_n
);
    // R4
    pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm_p != pol_p) && (pwm_n != pol_n)));

    // R1
    moe_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |-> !moe);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> flag);

    // R8
    moe_rise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(moe) |-> !$past(brk_act));

    // R6
    flag_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && brk_act) |=> flag);
endmodule

bind pwm_guard pwm_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .brk_act(brk_act), .moe(moe), .flag(flag),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .pol_p(pol_p), .pol_n(pol_n)
);

// File: tb/pwm_guard_test.sv
module pwm_guard_test;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       ref_i = 1'b0, upd_i = 1'b0, brk_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic pwm_p, pwm_n, pen_p, pen_n, moe_o, brk_flag, irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_guard uut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .upd_i(upd_i), .brk_i(brk_i),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwm_p(pwm_p), .pwm_n(pwm_n), .pen_p(pen_p), .pen_n(pen_n),
        .moe_o(moe_o), .brk_flag(brk_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic mf(input logic [1:0] md, input logic r);
        case (md)
            2'd0: return r;
            2'd1: return 1'b0;
            2'd2: return 1'b1;
            default: return ~r;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5eed));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // reset state: idle levels 0, enables released, flag clear
        chk("R5 reset pins", {6'd0, pwm_p, pwm_n}, 8'h00);
        chk("R5 reset enables", {6'd0, pen_p, pen_n}, 8'h00);
        chk("R6 reset flag/irq/moe", {5'd0, moe_o, brk_flag, irq}, 8'h00);

        wr(3'd2, 8'h18); wr(3'd5, 8'd3); wr(3'd3, 8'h00); wr(3'd1, 8'h0B);
        wr(3'd0, 8'h01);
        tick(8);
        chk("R5 run enables", {6'd0, pen_p, pen_n}, 8'h03);
        chk("R10 steady low ref", {6'd0, pwm_p, pwm_n}, 8'h01);

        // R10 directed deadtime edges, D=3
        ref_i = 1'b1; tick(3);
        chk("R10 main before deadtime", {6'd0, pwm_p, pwm_n}, 8'h00);
        tick(1);
        chk("R10 main after deadtime", {6'd0, pwm_p, pwm_n}, 8'h02);
        ref_i = 1'b0; tick(1);
        chk("R10 both off at fall", {6'd0, pwm_p, pwm_n}, 8'h00);
        tick(2);
        chk("R10 comp before deadtime", {6'd0, pwm_p, pwm_n}, 8'h00);
        tick(1);
        chk("R10 comp after deadtime", {6'd0, pwm_p, pwm_n}, 8'h01);

        // R10/R11 random references, modes, polarities, deadtimes
        for (int blk = 0; blk < 8; blk++) begin
            logic [2:0] d;
            logic [1:0] md, pl;
            logic mq;
            int cnt;
            d  = 3'($urandom % 5);
            md = 2'($urandom % 4);
            pl = 2'($urandom % 4);
            wr(3'd5, {5'd0, d}); wr(3'd3, {6'd0, md}); wr(3'd2, {6'b000110, pl});
            tick(12);
            mq = mf(md, ref_i); cnt = 0;
            for (int c = 0; c < 40; c++) begin
                logic m;
                ref_i = 1'($urandom % 2);
                @(posedge clk);
                m = mf(md, ref_i);
                if (m != mq) cnt = int'(d);
                else if (cnt > 0) cnt--;
                mq = m;
                @(negedge clk);
                chk("R10 R11 random run", {6'd0, pwm_p, pwm_n},
                    {6'd0, (mq && cnt == 0) ^ pl[0], (!mq && cnt == 0) ^ pl[1]});
            end
        end
        wr(3'd2, 8'h18); wr(3'd3, 8'h00); wr(3'd5, 8'd3);
        ref_i = 1'b0; tick(8);

        // R1 asynchronous reaction
        brk_i = 1'b1; #1;
        chk("R1 moe cleared without edge", {7'd0, moe_o}, 8'h00);
        chk("R1 pins inactive without edge", {6'd0, pwm_p, pwm_n}, 8'h00);
        chk("R6 flag set", {6'd0, brk_flag, irq}, 8'h02);
        tick(6);
        chk("R3 still inactive at D+3", {6'd0, pwm_p, pwm_n}, 8'h00);
        tick(1);
        chk("R3 idle levels at D+4", {6'd0, pwm_p, pwm_n}, 8'h02);
        chk("R5 enables released", {6'd0, pen_p, pen_n}, 8'h00);

        wr(3'd0, 8'h01);
        chk("R8 software set blocked", {7'd0, moe_o}, 8'h00);
        wr(3'd0, 8'h04);
        chk("R6 clear blocked, irq raised", {6'd0, brk_flag, irq}, 8'h03);

        brk_i = 1'b0; tick(2);
        upd_i = 1'b1; tick(1); upd_i = 1'b0;
        chk("R7 no auto re-arm", {7'd0, moe_o}, 8'h00);
        wr(3'd0, 8'h07);
        chk("R7 software re-arm", {6'd0, moe_o, brk_flag}, 8'h03);
        wr(3'd0, 8'h05);
        chk("R6 flag cleared", {6'd0, brk_flag, irq}, 8'h00);

        // R7 automatic re-arm
        wr(3'd1, 8'h0F); tick(4);
        brk_i = 1'b1; tick(1); brk_i = 1'b0; tick(1);
        chk("R7 moe low before update", {7'd0, moe_o}, 8'h00);
        upd_i = 1'b1; tick(1); upd_i = 1'b0;
        chk("R7 auto re-arm", {7'd0, moe_o}, 8'h01);
        brk_i = 1'b1; tick(1);
        upd_i = 1'b1; tick(1); upd_i = 1'b0;
        chk("R8 update blocked", {7'd0, moe_o}, 8'h00);
        brk_i = 1'b0; tick(1);
        upd_i = 1'b1; tick(1); upd_i = 1'b0;
        wr(3'd0, 8'h05);

        // R4 both idle levels active, R5 off-state select kept
        wr(3'd2, 8'h1C); wr(3'd1, 8'h1B); tick(4);
        brk_i = 1'b1; tick(1); brk_i = 1'b0; tick(8);
        chk("R4 comp held inactive", {6'd0, pwm_p, pwm_n}, 8'h02);
        chk("R5 enables kept", {6'd0, pen_p, pen_n}, 8'h03);

        // R2 break disabled
        wr(3'd1, 8'h1A); wr(3'd0, 8'h05); tick(4);
        brk_i = 1'b1; tick(2);
        chk("R2 moe unaffected", {7'd0, moe_o}, 8'h01);
        chk("R2 pins unaffected", {6'd0, pwm_p, pwm_n}, 8'h01);
        brk_i = 1'b0;

        // R9 lock
        wr(3'd1, 8'h0B); wr(3'd4, 8'h01);
        wr(3'd1, 8'h00);
        brk_i = 1'b1; tick(1);
        chk("R9 guard frozen", {7'd0, moe_o}, 8'h00);
        brk_i = 1'b0;
        wr(3'd4, 8'h03);
        wr(3'd2, 8'h19); wr(3'd3, 8'h02);
        wr(3'd0, 8'h05); tick(10);
        chk("R9 relock ignored", {6'd0, pwm_p, pwm_n}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule